// File: doc/BRIEF.md
# Coprocessor Instruction-Stream Snoop Unit

This block sits beside a host processor and listens to its multiplexed data/address bus without ever driving it or starting a bus cycle. The host reports each bus cycle with a 4-bit cycle-type code, which is read when the bus-cycle strobe rises. When the code marks either kind of instruction-stream read (a demand read or a request/prefetch read), the block copies the bus word into a holding instruction register. A cache-hit cycle is copied on the trailing edge of the address-latch strobe. A non-cache cycle is copied on the trailing edge of the data-valid strobe. Each new instruction-stream read replaces the previous word.

When the host raises its instruction-decode indicator, the block tests the held word. If the top four bits are all ones, the word is a floating-point instruction. The block then wakes, emits a one-cycle valid pulse carrying the opcode, accumulator and operand-mode fields, and keeps the register frozen while the execution side works. The execution side ends that interval with a done pulse. If the word is not a floating-point instruction, the block stays asleep and goes on copying instruction-stream words.

All host strobes are sampled on the system clock. A trailing edge is a registered 1-to-0 transition, and the word that is copied is the bus value from the last clock at which the strobe was still high.

Top module: `istream_snoop`

## Requirements
- R1: While reset is high, and on the cycle after it, the held word is 0, wake is low and the valid pulse is low.
- R2: A cycle whose code equals the demand-read code (default 4'h2), with cache-hit high, loads the held word with the bus value on the clock edge that detects the address-latch strobe falling.
- R3: A cycle whose code equals the request-read code (default 4'h3) loads the held word in the same way as a demand read.
- R4: With cache-hit low, the falling address-latch strobe leaves the held word unchanged, and the falling data-valid strobe loads it.
- R5: The data-read (4'h5), write (4'h6), general-register read (4'h9) and general-register write (4'hA) codes leave the held word unchanged. So does any unassigned code.
- R6: Successive instruction-stream reads each overwrite the held word with their own bus value.
- R7: A rising decode indicator on a word whose bits [15:12] are not 4'hF leaves wake and valid low, and later instruction-stream reads are still captured.
- R8: A rising decode indicator on a word with bits [15:12] == 4'hF raises wake on the next clock. On that clock the valid output pulses high for exactly one cycle, with opcode = bits [11:8], accumulator = bits [7:6] and mode = bits [5:0].
- R9: While awake, instruction-stream reads do not change the held word. A done pulse drops wake on the next clock, and capture then resumes.
- R10: The held word changes only on the clock edge at which the relevant strobe is first seen low, and not while that strobe is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_type_i | input | 4 | Host bus-cycle type code |
| bus_strobe_i | input | 1 | Bus-cycle start strobe; qualifies the code |
| addr_latch_i | input | 1 | Address-latch strobe; trailing edge captures cache-hit data |
| data_valid_i | input | 1 | Data-valid strobe; trailing edge captures non-cache data |
| cache_hit_i | input | 1 | High when the current cycle is served by the cache |
| decode_i | input | 1 | Host instruction-decode indicator |
| bus_i | input | 16 | Multiplexed data/address bus |
| exec_done_i | input | 1 | Execution side finished with the handed-over instruction |
| held_word_o | output | 16 | Holding instruction register |
| wake_o | output | 1 | High while a floating-point instruction is being handled |
| instr_valid_o | output | 1 | One-cycle pulse when the fields below are handed over |
| opcode_o | output | 4 | Opcode field of the accepted word |
| acc_o | output | 2 | Accumulator field of the accepted word |
| mode_o | output | 6 | Source/destination mode field of the accepted word |

## Verification
The hardest case is a non-cache cycle. The address-latch strobe falls while cache-hit is low, and the data-valid strobe falls a few clocks later. The bench must show that only the second edge copies the word. To reach it, the bench drives a complete bus cycle clock by clock from a task and samples the held word between the two trailing edges. A second hard case is an instruction-stream read made while the block is awake, which must be ignored. The bench reaches it by decoding a floating-point word, running a read before issuing done, and then running another read after done.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

    localparam int WORD_W  = 16;
    localparam int CODE_W  = 4;
    localparam int OPC_W   = 4;
    localparam int ACC_W   = 2;
    localparam int MODE_W  = 6;
    localparam int MARK_W  = WORD_W - OPC_W - ACC_W - MODE_W;

    typedef enum logic [2:0] {
        CYC_NONE,
        CYC_IDEMAND,
        CYC_IREQUEST,
        CYC_DREAD,
        CYC_WRITE,
        CYC_GREG_RD,
        CYC_GREG_WR
    } cyc_kind_e;

    typedef struct packed {
        logic [MARK_W-1:0] mark;
        logic [OPC_W-1:0]  opcode;
        logic [ACC_W-1:0]  acc;
        logic [MODE_W-1:0] mode;
    } fp_word_t;

    typedef enum logic {
        ST_SNOOP,
        ST_AWAKE
    } snoop_state_e;

    function automatic logic is_fp_word(input fp_word_t w);
        return &w.mark;
    endfunction

    function automatic logic is_istream(input cyc_kind_e k);
        return (k == CYC_IDEMAND) || (k == CYC_IREQUEST);
    endfunction

endpackage

// File: rtl/snoop_cycle_decode.sv
module snoop_cycle_decode
    import snoop_pkg::*;
#(
    parameter logic [CODE_W-1:0] CODE_IDEMAND  = 4'h2,
    parameter logic [CODE_W-1:0] CODE_IREQUEST = 4'h3,
    parameter logic [CODE_W-1:0] CODE_DREAD    = 4'h5,
    parameter logic [CODE_W-1:0] CODE_WRITE    = 4'h6,
    parameter logic [CODE_W-1:0] CODE_GREG_RD  = 4'h9,
    parameter logic [CODE_W-1:0] CODE_GREG_WR  = 4'hA
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_i,
    input  logic              strobe_i,
    input  logic              taken_i,
    output logic              pend_o
);

    function automatic cyc_kind_e classify(input logic [CODE_W-1:0] c);
        if      (c == CODE_IDEMAND)  return CYC_IDEMAND;
        else if (c == CODE_IREQUEST) return CYC_IREQUEST;
        else if (c == CODE_DREAD)    return CYC_DREAD;
        else if (c == CODE_WRITE)    return CYC_WRITE;
        else if (c == CODE_GREG_RD)  return CYC_GREG_RD;
        else if (c == CODE_GREG_WR)  return CYC_GREG_WR;
        else                         return CYC_NONE;
    endfunction

    logic strobe_q;
    logic strobe_rise;

    assign strobe_rise = strobe_i && !strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            pend_o   <= 1'b0;
        end else begin
            strobe_q <= strobe_i;
            if (strobe_rise)
                pend_o <= is_istream(classify(code_i));
            else if (taken_i)
                pend_o <= 1'b0;
        end
    end

    // A non instruction-stream code never arms capture (R5)
    assert_no_arm_datacycle_R5: assert property (@(posedge clk) disable iff (rst)
        (strobe_rise && !is_istream(classify(code_i))) |=> !pend_o);

endmodule

// File: rtl/snoop_capture.sv
module snoop_capture
    import snoop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pend_i,
    input  logic              enable_i,
    input  logic              hit_i,
    input  logic              ale_i,
    input  logic              dv_i,
    input  logic [WORD_W-1:0] bus_i,
    output logic              taken_o,
    output logic [WORD_W-1:0] word_o
);

    logic              ale_q;
    logic              dv_q;
    logic [WORD_W-1:0] bus_q;
    logic              ale_fall;
    logic              dv_fall;

    assign ale_fall = ale_q && !ale_i;
    assign dv_fall  = dv_q && !dv_i;
    assign taken_o  = pend_i && enable_i &&
                      ((hit_i && ale_fall) || (!hit_i && dv_fall));

    always_ff @(posedge clk) begin
        if (rst) begin
            ale_q  <= 1'b0;
            dv_q   <= 1'b0;
            bus_q  <= '0;
            word_o <= '0;
        end else begin
            ale_q <= ale_i;
            dv_q  <= dv_i;
            bus_q <= bus_i;
            if (taken_o)
                word_o <= bus_q;
        end
    end

    // Held word frozen while awake (R9)
    assert_frozen_awake_R9: assert property (@(posedge clk) disable iff (rst)
        !enable_i |=> $stable(word_o));

    // Nothing captured without an armed instruction-stream cycle (R5)
    assert_no_capture_unarmed_R5: assert property (@(posedge clk) disable iff (rst)
        !pend_i |=> $stable(word_o));

    // No capture while both strobes are still high (R10)
    assert_no_early_capture_R10: assert property (@(posedge clk) disable iff (rst)
        (ale_i && dv_i) |=> $stable(word_o));

endmodule

// File: rtl/snoop_wake_fsm.sv
module snoop_wake_fsm
    import snoop_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     decode_i,
    input  logic     done_i,
    input  fp_word_t word_i,
    output logic     snooping_o,
    output logic     wake_o,
    output logic     valid_o,
    output fp_word_t fields_o
);

    snoop_state_e state;
    logic         decode_q;
    logic         decode_rise;

    assign decode_rise = decode_i && !decode_q;
    assign snooping_o  = (state == ST_SNOOP);
    assign wake_o      = (state == ST_AWAKE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_SNOOP;
            decode_q <= 1'b0;
            valid_o  <= 1'b0;
            fields_o <= '0;
        end else begin
            decode_q <= decode_i;
            valid_o  <= 1'b0;
            unique case (state)
                ST_SNOOP: begin
                    if (decode_rise && is_fp_word(word_i)) begin
                        state    <= ST_AWAKE;
                        valid_o  <= 1'b1;
                        fields_o <= word_i;
                    end
                end
                ST_AWAKE: begin
                    if (done_i)
                        state <= ST_SNOOP;
                end
                default: state <= ST_SNOOP;
            endcase
        end
    end

    assert_valid_single_R8: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    assert_valid_with_wake_R8: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> wake_o);

    assert_nonfp_stays_asleep_R7: assert property (@(posedge clk) disable iff (rst)
        (snooping_o && !is_fp_word(word_i)) |=> !wake_o);

    assert_done_sleeps_R9: assert property (@(posedge clk) disable iff (rst)
        (wake_o && done_i) |=> !wake_o);

endmodule

// File: rtl/istream_snoop.sv
module istream_snoop
    import snoop_pkg::*;
#(
    parameter logic [3:0] CODE_IDEMAND  = 4'h2,
    parameter logic [3:0] CODE_IREQUEST = 4'h3,
    parameter logic [3:0] CODE_DREAD    = 4'h5,
    parameter logic [3:0] CODE_WRITE    = 4'h6,
    parameter logic [3:0] CODE_GREG_RD  = 4'h9,
    parameter logic [3:0] CODE_GREG_WR  = 4'hA
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  cyc_type_i,
    input  logic        bus_strobe_i,
    input  logic        addr_latch_i,
    input  logic        data_valid_i,
    input  logic        cache_hit_i,
    input  logic        decode_i,
    input  logic [15:0] bus_i,
    input  logic        exec_done_i,
    output logic [15:0] held_word_o,
    output logic        wake_o,
    output logic        instr_valid_o,
    output logic [3:0]  opcode_o,
    output logic [1:0]  acc_o,
    output logic [5:0]  mode_o
);

    logic     pend;
    logic     taken;
    logic     snooping;
    fp_word_t fields;

    snoop_cycle_decode #(
        .CODE_IDEMAND (CODE_IDEMAND),
        .CODE_IREQUEST(CODE_IREQUEST),
        .CODE_DREAD   (CODE_DREAD),
        .CODE_WRITE   (CODE_WRITE),
        .CODE_GREG_RD (CODE_GREG_RD),
        .CODE_GREG_WR (CODE_GREG_WR)
    ) u_cycle (
        .clk     (clk),
        .rst     (rst),
        .code_i  (cyc_type_i),
        .strobe_i(bus_strobe_i),
        .taken_i (taken),
        .pend_o  (pend)
    );

    snoop_capture u_capture (
        .clk     (clk),
        .rst     (rst),
        .pend_i  (pend),
        .enable_i(snooping),
        .hit_i   (cache_hit_i),
        .ale_i   (addr_latch_i),
        .dv_i    (data_valid_i),
        .bus_i   (bus_i),
        .taken_o (taken),
        .word_o  (held_word_o)
    );

    snoop_wake_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .decode_i  (decode_i),
        .done_i    (exec_done_i),
        .word_i    (fp_word_t'(held_word_o)),
        .snooping_o(snooping),
        .wake_o    (wake_o),
        .valid_o   (instr_valid_o),
        .fields_o  (fields)
    );

    assign opcode_o = fields.opcode;
    assign acc_o    = fields.acc;
    assign mode_o   = fields.mode;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (held_word_o == '0 && !wake_o && !instr_valid_o));

endmodule

// File: tb/tb_istream_snoop.sv
module tb_istream_snoop;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cyc_type_i = '0;
    logic        bus_strobe_i = 1'b0;
    logic        addr_latch_i = 1'b0;
    logic        data_valid_i = 1'b0;
    logic        cache_hit_i = 1'b0;
    logic        decode_i = 1'b0;
    logic [15:0] bus_i = '0;
    logic        exec_done_i = 1'b0;
    logic [15:0] held_word_o;
    logic        wake_o;
    logic        instr_valid_o;
    logic [3:0]  opcode_o;
    logic [1:0]  acc_o;
    logic [5:0]  mode_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    istream_snoop dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Full bus cycle; mid_check samples the held word between the two trailing edges
    task automatic bus_cycle(input logic [3:0] code, input logic [15:0] data,
                             input logic hit, input string req,
                             input logic [15:0] before_word);
        @(negedge clk);
        cyc_type_i = code; bus_strobe_i = 1'b1; bus_i = data;
        addr_latch_i = 1'b1; cache_hit_i = hit;
        @(negedge clk);
        check(req, held_word_o, before_word);    // R10: strobes still high
        addr_latch_i = 1'b0;
        @(negedge clk);
        if (!hit) check(req, held_word_o, before_word); // R4: ALE edge ignored
        data_valid_i = 1'b1;
        @(negedge clk);
        data_valid_i = 1'b0;
        @(negedge clk);
        bus_strobe_i = 1'b0; bus_i = 16'hDEAD; cyc_type_i = 4'h0;
        @(negedge clk);
    endtask

    task automatic decode_pulse();
        @(negedge clk); decode_i = 1'b1;
        @(negedge clk); decode_i = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 held", held_word_o, 16'h0);
        check("R1 wake", wake_o, 1'b0);
        check("R1 valid", instr_valid_o, 1'b0);
    endtask

    task automatic t_demand_hit();
        bus_cycle(4'h2, 16'h1234, 1'b1, "R10", 16'h0);
        check("R2 demand hit", held_word_o, 16'h1234);
    endtask

    task automatic t_request_nocache();
        bus_cycle(4'h3, 16'h2468, 1'b0, "R4", 16'h1234);
        check("R3/R4 request dv", held_word_o, 16'h2468);
    endtask

    task automatic t_ignored_codes();
        bus_cycle(4'h5, 16'hAAAA, 1'b1, "R5", 16'h2468);
        check("R5 dread", held_word_o, 16'h2468);
        bus_cycle(4'h6, 16'hBBBB, 1'b0, "R5", 16'h2468);
        check("R5 write", held_word_o, 16'h2468);
        bus_cycle(4'h9, 16'hCCCC, 1'b1, "R5", 16'h2468);
        bus_cycle(4'hA, 16'hDDDD, 1'b0, "R5", 16'h2468);
        bus_cycle(4'hF, 16'hEEEE, 1'b1, "R5", 16'h2468);
        check("R5 greg/unassigned", held_word_o, 16'h2468);
    endtask

    task automatic t_overwrite();
        bus_cycle(4'h2, 16'h0101, 1'b1, "R6", 16'h2468);
        bus_cycle(4'h3, 16'h0202, 1'b1, "R6", 16'h0101);
        check("R6 overwrite", held_word_o, 16'h0202);
    endtask

    task automatic t_nonfp_decode();
        bus_cycle(4'h2, 16'hE123, 1'b1, "R7", 16'h0202);
        decode_pulse();
        check("R7 wake", wake_o, 1'b0);
        check("R7 valid", instr_valid_o, 1'b0);
        @(negedge clk);
        check("R7 wake later", wake_o, 1'b0);
        bus_cycle(4'h3, 16'h0777, 1'b0, "R7", 16'hE123);
        check("R7 still capturing", held_word_o, 16'h0777);
    endtask

    task automatic t_fp_decode();
        // 1111 0110 10 011101 -> opcode 6, acc 2, mode 1D
        bus_cycle(4'h2, 16'hF69D, 1'b1, "R8", 16'h0777);
        decode_pulse();
        check("R8 wake", wake_o, 1'b1);
        check("R8 valid", instr_valid_o, 1'b1);
        check("R8 opcode", opcode_o, 4'h6);
        check("R8 acc", acc_o, 2'h2);
        check("R8 mode", mode_o, 6'h1D);
        @(negedge clk);
        check("R8 valid single", instr_valid_o, 1'b0);
        check("R8 wake held", wake_o, 1'b1);
    endtask

    task automatic t_awake_freeze();
        bus_cycle(4'h2, 16'h5555, 1'b1, "R9", 16'hF69D);
        check("R9 frozen", held_word_o, 16'hF69D);
        check("R9 wake", wake_o, 1'b1);
        @(negedge clk); exec_done_i = 1'b1;
        @(negedge clk); exec_done_i = 1'b0;
        check("R9 sleep", wake_o, 1'b0);
        bus_cycle(4'h3, 16'h6666, 1'b1, "R9", 16'hF69D);
        check("R9 resume", held_word_o, 16'h6666);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_demand_hit();
        t_request_nocache();
        t_ignored_codes();
        t_overwrite();
        t_nonfp_decode();
        t_fp_decode();
        t_awake_freeze();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule